// File: doc/BRIEF.md
# Multichannel Debug FIFO Register Block

This block moves 32-bit words between a processor and an external debug host over sixteen logical channels. The processor sees a small register window on a simple 32-bit read/write bus. Writing one of sixteen per-channel transmit slots queues the word in a transmit FIFO, tagged with the slot's channel number. Reading the receive slot takes the oldest word from a receive FIFO. The debug host side is a pair of plain ports. The host drains transmit entries together with their channel tags, and it fills the receive FIFO with words that carry a channel tag of their own.

A status register reports the occupancy and the empty/full flags of both FIFOs. It also gives the channel of the word at the receive head, so software knows where a word belongs before it pops it. A configuration register reports both FIFO depths and holds two 2-bit interrupt condition selectors, one for each direction. These drive a single level-sensitive interrupt line.

Top module: `dbgchan_regblk`

## Requirements
- R1: After reset both FIFOs are empty, both interrupt selectors are 0, the interrupt output is low, and the status word (byte offset 0x10) reads 0x0000000A.
- R2: The configuration word at offset 0x08 reads {12'b0, tx_sel[1:0] at bits 19:18, rx_sel[1:0] at bits 17:16, TX depth at bits 15:8, RX depth at bits 7:0}. A write changes only bits 19:16.
- R3: A write to offset 0x20 + 8*n (n = 0..15) appends the written word to the transmit FIFO with tag n. The host port shows the oldest entry (word and tag) whenever the FIFO is not empty, and host_tx_pop removes it.
- R4: A push into a FIFO that is full at the start of the cycle is discarded and leaves the contents unchanged, even when a pop happens in the same cycle.
- R5: The status word is {TX count[31:24], RX count[23:16], 8'b0, RX head tag[7:4], RX empty[3], RX full[2], TX empty[1], TX full[0]}. The head tag reads 0 when the RX FIFO is empty.
- R6: A read of offset 0x18 returns the receive head word and removes it in the same cycle.
- R7: A read of offset 0x18 while the receive FIFO is empty returns 0 and removes nothing.
- R8: host_rx_ready is high exactly when the receive FIFO is not full. A host push while it is full is dropped.
- R9: The TX selector picks the transmit condition: 0 never, 1 empty, 2 not full, 3 count*4 <= depth.
- R10: The RX selector picks the receive condition: 0 never, 1 full, 2 not empty, 3 count*4 >= 3*depth.
- R11: irq is the OR of the selected TX condition and the selected RX condition. It follows the current FIFO state in every cycle.
- R12: A push and a pop on the same FIFO in one cycle both take effect when the FIFO is neither full nor empty, and the count stays the same.
- R13: Offset 0x00, unaligned offsets and offsets above the last transmit slot read as 0. Writes to them, and to the status and receive offsets, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops when it addresses the receive slot) |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the same cycle |
| host_tx_pop | input | 1 | Host removes the transmit head |
| host_tx_valid | output | 1 | Transmit FIFO holds at least one entry |
| host_tx_data | output | 32 | Transmit head word |
| host_tx_chan | output | 4 | Transmit head channel tag |
| host_rx_push | input | 1 | Host appends a receive entry |
| host_rx_data | input | 32 | Receive word from the host |
| host_rx_chan | input | 4 | Channel tag of the receive word |
| host_rx_ready | output | 1 | Receive FIFO can accept a word |
| irq | output | 1 | Level interrupt |

## Verification
Each FIFO has two owners that can act in the same cycle. On the transmit side, a bus write to a channel slot can coincide with a host pop. On the receive side, a host push can coincide with a bus read of the receive slot. The bench issues both operations in a single cycle with the FIFO partly filled, completely full and completely empty. A behavioural queue model judges the resulting counts, returned data and head tags against the rule that fullness and emptiness are taken from the start of the cycle.

// File: rtl/dbgchan_pkg.sv
package dbgchan_pkg;

  localparam int unsigned REG_W = 32;

  localparam int unsigned OFS_ACCESS = 'h00;
  localparam int unsigned OFS_CFG    = 'h08;
  localparam int unsigned OFS_STAT   = 'h10;
  localparam int unsigned OFS_RXPOP  = 'h18;
  localparam int unsigned OFS_TXBASE = 'h20;
  localparam int unsigned TX_STRIDE  = 8;

  localparam int unsigned CFG_TXSEL_LSB = 18;
  localparam int unsigned CFG_RXSEL_LSB = 16;

  typedef enum logic [1:0] {
    TXI_OFF     = 2'd0,
    TXI_EMPTY   = 2'd1,
    TXI_NOTFULL = 2'd2,
    TXI_LOW     = 2'd3
  } tx_sel_e;

  typedef enum logic [1:0] {
    RXI_OFF      = 2'd0,
    RXI_FULL     = 2'd1,
    RXI_NOTEMPTY = 2'd2,
    RXI_HIGH     = 2'd3
  } rx_sel_e;

  // occupancy at or below a quarter of depth
  function automatic logic low_mark(input int unsigned cnt, input int unsigned depth);
    return (cnt * 4) <= depth;
  endfunction

  // occupancy at or above three quarters of depth
  function automatic logic high_mark(input int unsigned cnt, input int unsigned depth);
    return (cnt * 4) >= (depth * 3);
  endfunction

  function automatic logic tx_cond(input tx_sel_e sel, input int unsigned cnt,
                                   input int unsigned depth);
    case (sel)
      TXI_EMPTY:   return cnt == 0;
      TXI_NOTFULL: return cnt < depth;
      TXI_LOW:     return low_mark(cnt, depth);
      default:     return 1'b0;
    endcase
  endfunction

  function automatic logic rx_cond(input rx_sel_e sel, input int unsigned cnt,
                                   input int unsigned depth);
    case (sel)
      RXI_FULL:     return cnt == depth;
      RXI_NOTEMPTY: return cnt != 0;
      RXI_HIGH:     return high_mark(cnt, depth);
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbgchan_fifo.sv
module dbgchan_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push_req,
  input  logic [DATA_W-1:0]             push_data,
  input  logic [TAG_W-1:0]              push_tag,
  input  logic                          pop_req,
  output logic [DATA_W-1:0]             head_data,
  output logic [TAG_W-1:0]              head_tag,
  output logic [$clog2(DEPTH+1)-1:0]    level,
  output logic                          is_full,
  output logic                          is_empty,
  output logic                          push_done,
  output logic                          pop_done
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign is_full   = (level == CNT_W'(DEPTH));
  assign is_empty  = (level == '0);
  assign push_done = push_req && !is_full;
  assign pop_done  = pop_req && !is_empty;

  assign head_data = is_empty ? '0 : data_mem[rd_ptr];
  assign head_tag  = is_empty ? '0 : tag_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_done) begin
      data_mem[wr_ptr] <= push_data;
      tag_mem[wr_ptr]  <= push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_done) wr_ptr <= step_ptr(wr_ptr);
      if (pop_done)  rd_ptr <= step_ptr(rd_ptr);
      case ({push_done, pop_done})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)); // R4
  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && push_req && !pop_req) |=> $stable(level)); // R4
  AST_EMPTY_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && pop_req && !push_req) |=> $stable(level)); // R7
  AST_PAIR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_done && pop_done) |=> $stable(level)); // R12
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_full && is_empty)); // R5

endmodule

// File: rtl/dbgchan_decode.sv
module dbgchan_decode #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned CH_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_cfg,
  output logic              hit_stat,
  output logic              hit_rx,
  output logic              hit_tx,
  output logic [CH_W-1:0]   tx_chan
);
  import dbgchan_pkg::*;

  logic [NUM_CH-1:0] ch_match;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    assign ch_match[g] = (addr == ADDR_W'(OFS_TXBASE + TX_STRIDE * g));
  end

  always_comb begin
    tx_chan = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_match[i]) tx_chan = CH_W'(i);
    end
  end

  assign hit_tx   = |ch_match;
  assign hit_cfg  = (addr == ADDR_W'(OFS_CFG));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));
  assign hit_rx   = (addr == ADDR_W'(OFS_RXPOP));

endmodule

// File: rtl/dbgchan_irq.sv
module dbgchan_irq #(
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8,
  parameter int unsigned TXC_W    = 4,
  parameter int unsigned RXC_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dbgchan_pkg::tx_sel_e  tx_sel,
  input  dbgchan_pkg::rx_sel_e  rx_sel,
  input  logic [TXC_W-1:0]      tx_level,
  input  logic [RXC_W-1:0]      rx_level,
  output logic                  irq
);
  import dbgchan_pkg::*;

  logic tx_hit, rx_hit;

  assign tx_hit = tx_cond(tx_sel, 32'(tx_level), TX_DEPTH);
  assign rx_hit = rx_cond(rx_sel, 32'(rx_level), RX_DEPTH);
  assign irq    = tx_hit | rx_hit;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == TXI_OFF && rx_sel == RXI_OFF) |-> !irq); // R11
  AST_TX_EMPTY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == TXI_EMPTY && tx_level == '0) |-> irq); // R9
  AST_RX_FULL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel == RXI_FULL && rx_level == RXC_W'(RX_DEPTH)) |-> irq); // R10

endmodule

// File: rtl/dbgchan_regblk.sv
module dbgchan_regblk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned TX_DEPTH = 8,
  parameter int unsigned RX_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [31:0]                 bus_wdata,
  input  logic                        bus_rd,
  output logic [31:0]                 bus_rdata,
  input  logic                        host_tx_pop,
  output logic                        host_tx_valid,
  output logic [31:0]                 host_tx_data,
  output logic [$clog2(NUM_CH)-1:0]   host_tx_chan,
  input  logic                        host_rx_push,
  input  logic [31:0]                 host_rx_data,
  input  logic [$clog2(NUM_CH)-1:0]   host_rx_chan,
  output logic                        host_rx_ready,
  output logic                        irq
);
  import dbgchan_pkg::*;

  localparam int unsigned CH_W  = $clog2(NUM_CH);
  localparam int unsigned TXC_W = $clog2(TX_DEPTH + 1);
  localparam int unsigned RXC_W = $clog2(RX_DEPTH + 1);

  logic            hit_cfg, hit_stat, hit_rx, hit_tx;
  logic [CH_W-1:0] dec_chan;

  tx_sel_e tx_sel;
  rx_sel_e rx_sel;

  logic [TXC_W-1:0] tx_level;
  logic [RXC_W-1:0] rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_push_done, tx_pop_done, rx_push_done, rx_pop_done;
  logic [31:0]      rx_head_data;
  logic [CH_W-1:0]  rx_head_tag;
  logic             tx_push, rx_pop;

  dbgchan_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_decode (
    .addr(bus_addr), .hit_cfg(hit_cfg), .hit_stat(hit_stat),
    .hit_rx(hit_rx), .hit_tx(hit_tx), .tx_chan(dec_chan)
  );

  assign tx_push = bus_wr && hit_tx;
  assign rx_pop  = bus_rd && hit_rx;

  dbgchan_fifo #(.DATA_W(REG_W), .TAG_W(CH_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push_req(tx_push), .push_data(bus_wdata), .push_tag(dec_chan),
    .pop_req(host_tx_pop), .head_data(host_tx_data), .head_tag(host_tx_chan),
    .level(tx_level), .is_full(tx_full), .is_empty(tx_empty),
    .push_done(tx_push_done), .pop_done(tx_pop_done)
  );

  dbgchan_fifo #(.DATA_W(REG_W), .TAG_W(CH_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push_req(host_rx_push), .push_data(host_rx_data), .push_tag(host_rx_chan),
    .pop_req(rx_pop), .head_data(rx_head_data), .head_tag(rx_head_tag),
    .level(rx_level), .is_full(rx_full), .is_empty(rx_empty),
    .push_done(rx_push_done), .pop_done(rx_pop_done)
  );

  assign host_tx_valid = !tx_empty;
  assign host_rx_ready = !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sel <= TXI_OFF;
      rx_sel <= RXI_OFF;
    end else if (bus_wr && hit_cfg) begin
      tx_sel <= tx_sel_e'(bus_wdata[CFG_TXSEL_LSB +: 2]);
      rx_sel <= rx_sel_e'(bus_wdata[CFG_RXSEL_LSB +: 2]);
    end
  end

  dbgchan_irq #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
                .TXC_W(TXC_W), .RXC_W(RXC_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel), .rx_sel(rx_sel),
    .tx_level(tx_level), .rx_level(rx_level), .irq(irq)
  );

  logic [31:0] cfg_word, stat_word;

  assign cfg_word  = {12'h000, tx_sel, rx_sel, 8'(TX_DEPTH), 8'(RX_DEPTH)};
  assign stat_word = {8'(tx_level), 8'(rx_level), 8'h00, 4'(rx_head_tag),
                      rx_empty, rx_full, tx_empty, tx_full};

  always_comb begin
    bus_rdata = '0;
    if (hit_cfg)       bus_rdata = cfg_word;
    else if (hit_stat) bus_rdata = stat_word;
    else if (hit_rx)   bus_rdata = rx_head_data;
  end

  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty) |-> (!rx_pop_done && bus_rdata == '0)); // R7
  AST_RX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rx_push && !host_rx_ready) |-> !rx_push_done); // R8
  AST_TX_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tx_pop && !host_tx_valid) |-> !tx_pop_done); // R3
  AST_TX_TAG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_done && tx_empty) |=> (host_tx_chan == $past(dec_chan))); // R3
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_cfg) |=> ($stable(tx_sel) && $stable(rx_sel))); // R2

endmodule

// File: tb/dbgchan_regblk_bench.sv
module dbgchan_regblk_bench;

  localparam int TXD = 8;
  localparam int RXD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        host_tx_pop = 1'b0;
  logic        host_tx_valid;
  logic [31:0] host_tx_data;
  logic [3:0]  host_tx_chan;
  logic        host_rx_push = 1'b0;
  logic [31:0] host_rx_data = '0;
  logic [3:0]  host_rx_chan = '0;
  logic        host_rx_ready;
  logic        irq;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  dbgchan_regblk u_dbgchan_regblk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .host_tx_pop(host_tx_pop), .host_tx_valid(host_tx_valid),
    .host_tx_data(host_tx_data), .host_tx_chan(host_tx_chan),
    .host_rx_push(host_rx_push), .host_rx_data(host_rx_data),
    .host_rx_chan(host_rx_chan), .host_rx_ready(host_rx_ready), .irq(irq)
  );

  int total = 0;
  int bad   = 0;

  // behavioural model: {tag, word}
  logic [35:0] txq[$];
  logic [35:0] rxq[$];
  logic [1:0]  m_txsel = 0, m_rxsel = 0;
  logic [31:0] seen_rdata = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit is_tx_slot(input logic [7:0] a);
    return a >= 8'h20 && a <= 8'h98 && a[2:0] == 3'b000;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int nt = txq.size();
    int nr = rxq.size();
    case (a)
      8'h08: return {12'h0, m_txsel, m_rxsel, 8'(TXD), 8'(RXD)};
      8'h10: return {8'(nt), 8'(nr), 8'h00, (nr > 0) ? rxq[0][35:32] : 4'h0,
                     nr == 0, nr == RXD, nt == 0, nt == TXD};
      8'h18: return (nr > 0) ? rxq[0][31:0] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit model_irq();
    int nt = txq.size();
    int nr = rxq.size();
    bit t = 0, r = 0;
    if (m_txsel == 1) t = (nt == 0);
    if (m_txsel == 2) t = (nt != TXD);
    if (m_txsel == 3) t = (nt <= TXD / 4);
    if (m_rxsel == 1) r = (nr == RXD);
    if (m_rxsel == 2) r = (nr > 0);
    if (m_rxsel == 3) r = (nr >= (3 * RXD + 3) / 4);
    return t || r;
  endfunction

  function automatic string read_req(input logic [7:0] a);
    case (a)
      8'h08: return "R2";
      8'h10: return "R5";
      8'h18: return "R6";
      default: return "R13";
    endcase
  endfunction

  // compare every cycle, then apply this cycle's inputs to the model
  always @(negedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete(); m_txsel = 0; m_rxsel = 0;
    end else begin
      logic [31:0] er;
      bit tfull, tempty, rfull, rempty;
      chk(host_tx_valid == (txq.size() > 0), "R3", "tx_valid",
          32'(host_tx_valid), 32'(txq.size() > 0));
      if (txq.size() > 0)
        chk({host_tx_chan, host_tx_data} == txq[0], "R3", "tx_head",
            host_tx_data, txq[0][31:0]);
      chk(host_rx_ready == (rxq.size() < RXD), "R8", "rx_ready",
          32'(host_rx_ready), 32'(rxq.size() < RXD));
      chk(irq == model_irq(), "R11", "irq", 32'(irq), 32'(model_irq()));
      if (bus_rd) begin
        er = model_read(bus_addr);
        seen_rdata = bus_rdata;
        chk(bus_rdata == er, read_req(bus_addr), "rdata", bus_rdata, er);
      end
      tfull = txq.size() == TXD; tempty = txq.size() == 0;
      rfull = rxq.size() == RXD; rempty = rxq.size() == 0;
      if (host_tx_pop && !tempty) void'(txq.pop_front());
      if (bus_wr && is_tx_slot(bus_addr) && !tfull)
        txq.push_back({4'((bus_addr - 8'h20) >> 3), bus_wdata});
      if (bus_rd && bus_addr == 8'h18 && !rempty) void'(rxq.pop_front());
      if (host_rx_push && !rfull) rxq.push_back({host_rx_chan, host_rx_data});
      if (bus_wr && bus_addr == 8'h08) begin
        m_txsel = bus_wdata[19:18];
        m_rxsel = bus_wdata[17:16];
      end
    end
  end

  task automatic drive(input bit wr, input bit rd, input logic [7:0] a,
                       input logic [31:0] d, input bit tp, input bit rp,
                       input logic [31:0] hd, input logic [3:0] hc);
    @(posedge clk); #1;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    host_tx_pop = tp; host_rx_push = rp; host_rx_data = hd; host_rx_chan = hc;
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; host_tx_pop = 0; host_rx_push = 0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    drive(1, 0, a, d, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(input logic [7:0] a);
    drive(0, 1, a, 0, 0, 0, 0, 0);
  endtask
  task automatic hpop();
    drive(0, 0, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic hpush(input logic [31:0] d, input logic [3:0] c);
    drive(0, 0, 0, 0, 0, 1, d, c);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog all actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_reg(8'h10);
    chk(seen_rdata == 32'h0000000A, "R1", "status after reset", seen_rdata, 32'h0000000A);
    chk(irq == 1'b0, "R1", "irq after reset", 32'(irq), 32'h0);

    // R2 configuration word
    rd_reg(8'h08);
    chk(seen_rdata == 32'h00000808, "R2", "cfg default", seen_rdata, 32'h00000808);
    wr_reg(8'h08, 32'hFFFF_FFFF);
    rd_reg(8'h08);
    chk(seen_rdata == 32'h000F0808, "R2", "cfg writable bits", seen_rdata, 32'h000F0808);
    wr_reg(8'h08, 32'h0);

    // R3 tagged transmit
    wr_reg(8'h48, 32'hA5A5_0005);
    chk(host_tx_valid && host_tx_chan == 4'd5 && host_tx_data == 32'hA5A5_0005,
        "R3", "tx slot 5", host_tx_data, 32'hA5A5_0005);
    wr_reg(8'h20, 32'h0000_1000);
    wr_reg(8'h98, 32'h0000_100F);
    repeat (3) hpop();
    chk(!host_tx_valid, "R3", "tx drained", 32'(host_tx_valid), 32'h0);

    // R4 transmit overflow discarded
    for (int i = 0; i < 9; i++) wr_reg(8'(8'h20 + 8 * (i % 16)), 32'(i + 32'h100));
    rd_reg(8'h10);
    chk(seen_rdata == 32'h08000009, "R4", "tx full status", seen_rdata, 32'h08000009);
    for (int i = 0; i < 8; i++) begin
      chk(host_tx_data == 32'(i + 32'h100), "R4", "tx order", host_tx_data, 32'(i + 32'h100));
      hpop();
    end

    // R5 R6 receive with head tag
    hpush(32'h11, 4'd3);
    hpush(32'h22, 4'd12);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h00020032, "R5", "rx status tag 3", seen_rdata, 32'h00020032);
    rd_reg(8'h18);
    chk(seen_rdata == 32'h11, "R6", "rx pop first", seen_rdata, 32'h11);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h000100C2, "R5", "rx status tag 12", seen_rdata, 32'h000100C2);
    rd_reg(8'h18);
    chk(seen_rdata == 32'h22, "R6", "rx pop second", seen_rdata, 32'h22);

    // R7 empty receive read
    rd_reg(8'h18);
    chk(seen_rdata == 32'h0, "R7", "rx empty read", seen_rdata, 32'h0);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h0000000A, "R7", "status after empty read", seen_rdata, 32'h0000000A);

    // R8 receive overflow
    for (int i = 0; i < 9; i++) hpush(32'(i + 32'h200), 4'(i));
    chk(!host_rx_ready, "R8", "rx ready low when full", 32'(host_rx_ready), 32'h0);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h00080006, "R8", "rx full status", seen_rdata, 32'h00080006);
    for (int i = 0; i < 8; i++) begin
      rd_reg(8'h18);
      chk(seen_rdata == 32'(i + 32'h200), "R8", "rx kept order", seen_rdata, 32'(i + 32'h200));
    end

    // R9 R10 directed interrupt points
    wr_reg(8'h08, 32'h0004_0000);
    chk(irq == 1'b1, "R9", "tx empty irq", 32'(irq), 32'h1);
    wr_reg(8'h08, 32'h000C_0000);
    wr_reg(8'h20, 32'h1); wr_reg(8'h20, 32'h2);
    chk(irq == 1'b1, "R9", "tx low mark at 2", 32'(irq), 32'h1);
    wr_reg(8'h20, 32'h3);
    chk(irq == 1'b0, "R9", "tx above low mark", 32'(irq), 32'h0);
    repeat (3) hpop();
    wr_reg(8'h08, 32'h0003_0000);
    for (int i = 0; i < 5; i++) hpush(32'(i), 4'h1);
    chk(irq == 1'b0, "R10", "rx below high mark", 32'(irq), 32'h0);
    hpush(32'h5, 4'h1);
    chk(irq == 1'b1, "R10", "rx high mark at 6", 32'(irq), 32'h1);
    repeat (6) rd_reg(8'h18);

    // R11 all selector pairs over full fill and drain (model checks irq each cycle)
    for (int s = 0; s < 16; s++) begin
      wr_reg(8'h08, 32'(s) << 16);
      for (int i = 0; i < TXD; i++) drive(1, 0, 8'h30, 32'(i), 0, 1, 32'(i), 4'h7);
      for (int i = 0; i < TXD; i++) drive(0, 1, 8'h18, 0, 1, 0, 0, 0);
    end
    wr_reg(8'h08, 32'h0006_0000);
    wr_reg(8'h20, 32'h9);
    hpush(32'h9, 4'h2);
    chk(irq == 1'b1, "R11", "rx side alone raises irq", 32'(irq), 32'h1);
    rd_reg(8'h18); hpop();
    chk(irq == 1'b1, "R11", "tx side alone raises irq", 32'(irq), 32'h1);
    wr_reg(8'h08, 32'h0);

    // R12 simultaneous push and pop
    for (int i = 0; i < 3; i++) wr_reg(8'h28, 32'(i + 32'h300));
    drive(1, 0, 8'h28, 32'h303, 1, 0, 0, 0);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h03000008, "R12", "tx count kept", seen_rdata, 32'h03000008);
    for (int i = 0; i < 5; i++) wr_reg(8'h28, 32'h400);
    drive(1, 0, 8'h28, 32'hDEAD, 1, 0, 0, 0);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h07000008, "R4", "full tx push with pop", seen_rdata, 32'h07000008);
    repeat (7) hpop();
    hpush(32'h51, 4'd1); hpush(32'h52, 4'd6);
    drive(0, 1, 8'h18, 0, 0, 1, 32'h53, 4'd9);
    chk(seen_rdata == 32'h51, "R12", "rx pop with push", seen_rdata, 32'h51);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h00020062, "R12", "rx count kept", seen_rdata, 32'h00020062);
    repeat (2) rd_reg(8'h18);
    drive(0, 1, 8'h18, 0, 0, 1, 32'h54, 4'd2);
    chk(seen_rdata == 32'h0, "R12", "empty rx pop with push", seen_rdata, 32'h0);
    rd_reg(8'h18);
    chk(seen_rdata == 32'h54, "R12", "push kept when empty", seen_rdata, 32'h54);

    // R13 unmapped and read-only offsets
    wr_reg(8'h00, 32'hFFFF_FFFF);
    wr_reg(8'h24, 32'h1);
    wr_reg(8'hA0, 32'h2);
    wr_reg(8'h10, 32'hFFFF_FFFF);
    wr_reg(8'h18, 32'h3);
    rd_reg(8'h10);
    chk(seen_rdata == 32'h0000000A, "R13", "status unchanged", seen_rdata, 32'h0000000A);
    rd_reg(8'h00);
    chk(seen_rdata == 32'h0, "R13", "offset 0 reads zero", seen_rdata, 32'h0);
    rd_reg(8'h9C);
    chk(seen_rdata == 32'h0, "R13", "unaligned reads zero", seen_rdata, 32'h0);

    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule